// File: doc/BRIEF.md
# Hardware Standby Power-Mode Sequencer

This block follows a chip's power state from two active-low pins: a standby request and a reset. Pulling the standby request low halts everything at once, whatever the block was doing. The oscillator stops, the clock gate closes and the pins are marked inactive. Leaving standby takes a fixed order. First the standby request is released while reset is still held. The oscillator then restarts and a programmable warm-up count runs. Only after that count may reset rise, which fires a one-cycle start pulse for power-on reset handling and returns the chip to execution.

RAM contents survive standby only when software has cleared the RAM enable bit beforehand. The block records the bit's value as standby begins. From it the block drives a retention output or a flag that marks the RAM contents as invalid. A reset that rises before the warm-up count has ended sets a sticky timing-violation flag. The start pulse is then held back until the count completes.

Top module: `stby_seq`

## Requirements
- R1: A low level on `stby_req_n` puts the block into standby at once, without waiting for a clock edge, from any mode. In standby `mode` = 2'b01, `osc_en` = 0, `clk_gate_en` = 0 and `pins_inactive` = 1. The mode encoding is 2'b00 execute, 2'b01 standby, 2'b10 warm-up and 2'b11 reset.
- R2: While `stby_req_n` is low, the block stays in standby whatever `res_n` does, and it raises no `por_start`.
- R3: The third rising clock edge after `stby_req_n` goes high moves the block from standby to warm-up. `stby_req_n` passes through a two-flop synchroniser. In warm-up `mode` = 2'b10, `osc_en` = 1 and `clk_gate_en` = 0.
- R4: `stable` reads 0 for the first `warm_cycles` clock edges after warm-up is entered and rises on the next edge, edge `warm_cycles`+1.
- R5: If `res_n` has been high for two synchronising edges and `stable` = 1, the next edge produces a `por_start` pulse one cycle wide. The same edge sets `mode` = 2'b00 and `clk_gate_en` = 1. A rise of `res_n` in reset mode does the same.
- R6: If `res_n` is seen high in warm-up before `stable` = 1, `timing_viol` goes to 1 and the block stays in warm-up. The `por_start` pulse follows on the edge after `stable` rises. `timing_viol` stays set until the next standby entry or the next `rst`.
- R7: `ram_en` is sampled on every clock edge outside standby, and the value held at entry decides the RAM outputs. If that value is 0, `ram_retain` = 1 throughout standby and `ram_invalid` = 0. If it is 1, `ram_retain` = 0 and `ram_invalid` becomes 1 on the first edge in standby. `ram_invalid` holds its value until the next standby entry or the next `rst`.
- R8: `ram_wprot` = 1 in every mode except execute, where it is 0.
- R9: A synchronous `rst` sets `mode` = 2'b11 and clears `por_start`, `timing_viol` and `ram_invalid`. A low `res_n` in execute moves the block to reset mode on the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high initialisation |
| stby_req_n | input | 1 | Active-low standby request, asynchronous |
| res_n | input | 1 | Active-low reset pin |
| ram_en | input | 1 | Software RAM enable bit |
| warm_cycles | input | CW | Warm-up count length |
| mode | output | 2 | Current power mode |
| osc_en | output | 1 | Oscillator enable |
| clk_gate_en | output | 1 | Global clock gate open |
| pins_inactive | output | 1 | Pins forced inactive |
| ram_wprot | output | 1 | RAM write protect |
| ram_retain | output | 1 | RAM retention active |
| ram_invalid | output | 1 | RAM contents not guaranteed |
| stable | output | 1 | Warm-up count complete |
| timing_viol | output | 1 | Reset released too early |
| por_start | output | 1 | One-cycle power-on reset start |

## Verification
The bench enters standby from execute, warm-up and reset mode and samples one time step later. A design that waited for a clock edge would still report the old mode at that point. It raises reset during warm-up well before the count ends and counts the edges until `stable` rises. An off-by-one counter, or a design that fires `por_start` early, breaks the edge count or the scoreboard's expected flag values. Toggling reset inside standby catches any design that leaves standby without the standby request, or that fires a spurious start pulse. Entering standby once with the RAM enable set and once with it cleared exposes a design that samples the bit at the wrong moment or loses the flag after exit.

// File: rtl/stby_pkg.sv
package stby_pkg;
  typedef enum logic [1:0] {
    MODE_EXEC = 2'b00,
    MODE_STBY = 2'b01,
    MODE_WARM = 2'b10,
    MODE_RST  = 2'b11
  } pmode_e;
endpackage

// File: rtl/stby_sync.sv
// Multi-stage level synchroniser; ASYNC_CLR picks a variant whose chain is
// cleared immediately by clr_n, otherwise clr_n acts synchronously.
module stby_sync #(
  parameter int STAGES    = 2,
  parameter bit ASYNC_CLR = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (ASYNC_CLR) begin : g_aclr
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)   chain <= '0;
        else if (rst) chain <= '0;
        else          chain <= {chain[STAGES-2:0], d};
      end
    end else begin : g_sclr
      always_ff @(posedge clk) begin
        if (rst || !clr_n) chain <= '0;
        else               chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/stby_warm_timer.sv
// Counts oscillator warm-up cycles while run is high; done is sticky until run drops.
module stby_warm_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [CW-1:0] limit,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (cnt == limit) begin
      done <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/stby_ram_guard.sv
// Tracks the software RAM enable outside standby and qualifies retention.
module stby_ram_guard (
  input  logic clk,
  input  logic rst,
  input  logic in_stby,
  input  logic ram_en,
  output logic retain,
  output logic invalid
);
  logic en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b1;
      invalid <= 1'b0;
    end else begin
      if (!in_stby) en_q    <= ram_en;
      else          invalid <= en_q;
    end
  end

  assign retain = in_stby & ~en_q;
endmodule

// File: rtl/stby_seq.sv
module stby_seq #(
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stby_req_n,
  input  logic          res_n,
  input  logic          ram_en,
  input  logic [CW-1:0] warm_cycles,
  output logic [1:0]    mode,
  output logic          osc_en,
  output logic          clk_gate_en,
  output logic          pins_inactive,
  output logic          ram_wprot,
  output logic          ram_retain,
  output logic          ram_invalid,
  output logic          stable,
  output logic          timing_viol,
  output logic          por_start
);
  import stby_pkg::*;

  pmode_e state, nxt;
  logic   stby_s, res_s;
  logic   fire, early;
  logic   in_stby;

  // Exit path only: chain is cleared the moment the request falls.
  stby_sync #(.STAGES(SYNC_STAGES), .ASYNC_CLR(1'b1)) u_stby_sync (
    .clk(clk), .rst(rst), .clr_n(stby_req_n), .d(1'b1), .q(stby_s)
  );

  stby_sync #(.STAGES(SYNC_STAGES), .ASYNC_CLR(1'b0)) u_res_sync (
    .clk(clk), .rst(rst), .clr_n(1'b1), .d(res_n), .q(res_s)
  );

  stby_warm_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .run(state == MODE_WARM),
    .limit(warm_cycles), .done(stable)
  );

  assign in_stby = (state == MODE_STBY);

  stby_ram_guard u_ram (
    .clk(clk), .rst(rst), .in_stby(in_stby), .ram_en(ram_en),
    .retain(ram_retain), .invalid(ram_invalid)
  );

  always_comb begin
    nxt   = state;
    fire  = 1'b0;
    early = 1'b0;
    unique case (state)
      MODE_EXEC: if (!res_s) nxt = MODE_RST;
      MODE_RST: if (res_s) begin
        nxt  = MODE_EXEC;
        fire = 1'b1;
      end
      MODE_STBY: if (stby_s) nxt = MODE_WARM;
      MODE_WARM: if (res_s) begin
        if (stable) begin
          nxt  = MODE_EXEC;
          fire = 1'b1;
        end else begin
          early = 1'b1;
        end
      end
      default: nxt = MODE_RST;
    endcase
  end

  // Standby entry is an asynchronous load that overrides everything.
  always_ff @(posedge clk or negedge stby_req_n) begin
    if (!stby_req_n) begin
      state       <= MODE_STBY;
      por_start   <= 1'b0;
      timing_viol <= 1'b0;
    end else if (rst) begin
      state       <= MODE_RST;
      por_start   <= 1'b0;
      timing_viol <= 1'b0;
    end else begin
      state       <= nxt;
      por_start   <= fire;
      timing_viol <= timing_viol | early;
    end
  end

  assign mode          = state;
  assign osc_en        = (state != MODE_STBY);
  assign clk_gate_en   = (state == MODE_EXEC);
  assign pins_inactive = in_stby;
  assign ram_wprot     = (state != MODE_EXEC);
endmodule

// File: rtl/stby_seq_chk.sv
module stby_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       stby_req_n,
  input logic [1:0] mode,
  input logic       osc_en,
  input logic       clk_gate_en,
  input logic       stable,
  input logic       timing_viol,
  input logic       por_start
);
  // R1
  stby_entry_chk: assert property (@(posedge clk) disable iff (rst)
    !stby_req_n |-> (mode == 2'b01 && !osc_en && !clk_gate_en));

  // R3
  warm_osc_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10) |-> (osc_en && !clk_gate_en));

  // R4
  por_after_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (por_start && $past(mode) == 2'b10) |-> $past(stable));

  // R5
  por_single_chk: assert property (@(posedge clk) disable iff (rst)
    por_start |=> !por_start);

  // R5
  por_exec_chk: assert property (@(posedge clk) disable iff (rst)
    por_start |-> (mode == 2'b00 && clk_gate_en));

  // R6
  viol_in_warm_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(timing_viol) |-> (mode == 2'b10));
endmodule

bind stby_seq stby_seq_chk u_chk (
  .clk(clk), .rst(rst), .stby_req_n(stby_req_n), .mode(mode),
  .osc_en(osc_en), .clk_gate_en(clk_gate_en), .stable(stable),
  .timing_viol(timing_viol), .por_start(por_start)
);

// File: tb/stby_seq_bench.sv
module stby_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CW         = 16;
  localparam int N          = 20;

  logic          clk = 1'b0;
  logic          rst, stby_req_n, res_n, ram_en;
  logic [CW-1:0] warm_cycles;
  logic [1:0]    mode;
  logic          osc_en, clk_gate_en, pins_inactive, ram_wprot;
  logic          ram_retain, ram_invalid, stable, timing_viol, por_start;

  int n_chk  = 0;
  int n_fail = 0;
  logic [1:0] exp_q[$];   // {timing_viol, ram_invalid} expected at each por_start

  always #(CLK_PERIOD/2) clk = ~clk;

  stby_seq #(.CW(CW)) u_stby_seq (
    .clk(clk), .rst(rst), .stby_req_n(stby_req_n), .res_n(res_n),
    .ram_en(ram_en), .warm_cycles(warm_cycles), .mode(mode),
    .osc_en(osc_en), .clk_gate_en(clk_gate_en), .pins_inactive(pins_inactive),
    .ram_wprot(ram_wprot), .ram_retain(ram_retain), .ram_invalid(ram_invalid),
    .stable(stable), .timing_viol(timing_viol), .por_start(por_start)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic expect_por(input logic viol, input logic rinv);
    exp_q.push_back({viol, rinv});
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Monitor: every start pulse pops one expected item
  always @(negedge clk) begin
    if (!rst && por_start === 1'b1) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R2/R5: actual unexpected por_start expected none");
      end else begin
        logic [1:0] e;
        e = exp_q.pop_front();
        chk("R6 viol at por", timing_viol, e[1]);
        chk("R7 ram_invalid at por", ram_invalid, e[0]);
        chk("R5 mode at por", mode, 2'b00);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int k;
    rst = 1'b1; stby_req_n = 1'b1; res_n = 1'b0; ram_en = 1'b1;
    warm_cycles = CW'(N);
    wait_neg(3);
    rst = 1'b0;
    wait_neg(1);
    // R9 reset state
    chk("R9 mode after rst", mode, 2'b11);
    chk("R9 por after rst", por_start, 1'b0);
    chk("R9 viol after rst", timing_viol, 1'b0);
    chk("R9 ram_invalid after rst", ram_invalid, 1'b0);
    chk("R8 wprot in reset", ram_wprot, 1'b1);

    // R5 release from reset mode
    res_n = 1'b1; expect_por(1'b0, 1'b0);
    wait_neg(3);
    chk("R5 mode exec", mode, 2'b00);
    chk("R5 clk gate open", clk_gate_en, 1'b1);
    chk("R8 wprot in exec", ram_wprot, 1'b0);
    wait_neg(1);
    chk("R5 single pulse", por_start, 1'b0);

    // R9 reset pin low in execute
    res_n = 1'b0;
    wait_neg(2);
    chk("R9 still exec after 2 edges", mode, 2'b00);
    wait_neg(1);
    chk("R9 reset mode", mode, 2'b11);
    res_n = 1'b1; expect_por(1'b0, 1'b0);
    wait_neg(3);
    chk("R5 exec again", mode, 2'b00);

    // R1 / R7 entry from execute with RAM enabled
    res_n = 1'b0;
    wait_neg(1);
    stby_req_n = 1'b0;
    #1;
    chk("R1 mode stby immediate", mode, 2'b01);
    chk("R1 osc off", osc_en, 1'b0);
    chk("R1 gate closed", clk_gate_en, 1'b0);
    chk("R1 pins inactive", pins_inactive, 1'b1);
    chk("R7 no retain with ram_en=1", ram_retain, 1'b0);
    wait_neg(1);
    chk("R7 invalid flagged", ram_invalid, 1'b1);

    // R2 reset pin toggles in standby are ignored
    res_n = 1'b1;
    wait_neg(4);
    chk("R2 stays stby", mode, 2'b01);
    res_n = 1'b0;
    wait_neg(3);
    chk("R2 still stby", mode, 2'b01);

    // R3 exit to warm-up
    stby_req_n = 1'b1;
    wait_neg(2);
    chk("R3 not yet warm", mode, 2'b01);
    wait_neg(1);
    chk("R3 warm mode", mode, 2'b10);
    chk("R3 osc on", osc_en, 1'b1);
    chk("R3 gate closed", clk_gate_en, 1'b0);
    chk("R8 wprot in warm", ram_wprot, 1'b1);

    // R6 early reset release
    res_n = 1'b1; expect_por(1'b1, 1'b1);
    wait_neg(3);
    chk("R6 viol set", timing_viol, 1'b1);
    chk("R6 held in warm", mode, 2'b10);
    k = 3;
    while (stable !== 1'b1 && k < N + 10) begin
      @(negedge clk);
      k++;
    end
    chk("R4 stable edge count", k, N + 1);
    chk("R6 no exec before pulse", mode, 2'b10);
    wait_neg(1);
    chk("R6 exec after stable", mode, 2'b00);
    chk("R7 invalid held after exit", ram_invalid, 1'b1);

    // R7 retention with ram_en cleared; R6 flag cleared on entry
    ram_en = 1'b0;
    wait_neg(2);
    res_n = 1'b0;
    wait_neg(1);
    stby_req_n = 1'b0;
    #1;
    chk("R7 retain", ram_retain, 1'b1);
    chk("R6 viol cleared on entry", timing_viol, 1'b0);
    wait_neg(1);
    chk("R7 valid", ram_invalid, 1'b0);

    // R1 entry from warm-up
    stby_req_n = 1'b1;
    wait_neg(3);
    chk("R3 warm again", mode, 2'b10);
    stby_req_n = 1'b0;
    #1;
    chk("R1 entry from warm", mode, 2'b01);

    // R4 / R5 clean exit
    wait_neg(1);
    stby_req_n = 1'b1;
    wait_neg(3);
    wait_neg(N);
    chk("R4 not stable at N", stable, 1'b0);
    wait_neg(1);
    chk("R4 stable at N+1", stable, 1'b1);
    res_n = 1'b1; expect_por(1'b0, 1'b0);
    wait_neg(2);
    chk("R5 waits for sync", mode, 2'b10);
    wait_neg(1);
    chk("R5 clean exec", mode, 2'b00);
    chk("R6 no viol clean", timing_viol, 1'b0);

    // R1 entry from reset mode
    res_n = 1'b0;
    wait_neg(3);
    chk("R9 reset mode again", mode, 2'b11);
    stby_req_n = 1'b0;
    #1;
    chk("R1 entry from reset", mode, 2'b01);
    wait_neg(3);

    chk("R5 all expected pulses seen", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule